// File: doc/BRIEF.md
# Bus-Programmable Watchdog Timer

The block is a watchdog peripheral on a simple word-addressed register bus. A 32-bit down-counter is loaded from a programmable reload register. Software keeps the system alive by writing a fixed key to a restart register. If the counter is allowed to reach zero, a sticky status flag is set. Up to three outputs then fire: a reset request, an interrupt and an external signal. Each output is a pulse whose length in bus-clock cycles is programmable.

The count can advance once per bus-clock cycle. It can instead advance once per rising edge of a slow external clock. That clock is brought into the bus-clock domain through a flop synchroniser, so its period must be more than twice the bus-clock period. Writes take effect on the clock edge at which `wr_en_i` is high. Read data is a combinational decode of `addr_i`.

Top module: `wdog_timer`

## Requirements
- R1: Registers are selected by `addr_i[4:2]`: 0 counter (read-only), 1 reload, 2 restart, 3 control, 4 status, 5 status clear, 6 pulse length. After reset the reload register reads 0x03EF1480 and the counter reads the same value. Control reads 0, status reads 0, pulse length reads 0xFF, and all three outputs are low.
- R2: Control bit 0 enables counting. While it is 0 the counter holds its value. A write that changes bit 0 from 0 to 1 copies the reload value into the counter.
- R3: When control bit 4 is 0 and counting is enabled, the counter drops by one on every bus-clock cycle.
- R4: A write of exactly 0x00005AB9 to the restart register copies the reload value into the counter. A write of any other value to that register leaves counting untouched.
- R5: When the counter steps from 1 to 0, status bit 0 is set. The counter then holds at zero until it is reloaded.
- R6: Writing 1 to bit 0 of the status-clear register clears status bit 0. Writing 0 there has no effect. If an expiry and a clear occur in the same cycle, the expiry wins.
- R7: Control bit 1 enables the reset output, bit 2 the interrupt output and bit 3 the external output. At expiry, each enabled output goes high in the first cycle in which the counter reads zero. It stays high for exactly as many cycles as the pulse-length value. A pulse-length value of 0 gives no pulse, and an output whose enable bit is clear stays low.
- R8: When control bit 4 is 1, the counter drops by one only for each rising edge of `ext_clk_i`. Each edge is detected after a two-flop synchroniser. With no edges, the counter does not change.
- R9: Each expiry produces exactly one pulse per enabled output. Once the pulse has ended, the outputs stay low while the counter sits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 5 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| ext_clk_i | input | 1 | Slow external count clock |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_sig_o | output | 1 | External signal pulse |

## Verification
The bench builds the block with its default parameters. These are a 32-bit counter, an 8-bit pulse length, a two-stage synchroniser and the one-second reset value for the reload register. The bench checks the reset value as it comes out of reset. It then programs a reload of 10 or 3 over the bus, so expiry, pulse length and hold-at-zero all fall within a few dozen cycles. Pulse lengths of 3, 2 and 0 cover a normal pulse, a short pulse and the no-pulse case. Three slow external-clock edges are enough to reach expiry in external mode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [2:0] {
    REG_COUNT   = 3'd0,
    REG_RELOAD  = 3'd1,
    REG_RESTART = 3'd2,
    REG_CTRL    = 3'd3,
    REG_STATUS  = 3'd4,
    REG_CLEAR   = 3'd5,
    REG_PLEN    = 3'd6
  } wd_reg_e;

  typedef struct packed {
    logic clk_ext;
    logic ext_en;
    logic irq_en;
    logic rst_en;
    logic cnt_en;
  } wd_ctrl_t;

  localparam int unsigned NUM_OUT = 3;
  localparam int unsigned IDX_LSB = 2;
  localparam int unsigned IDX_W   = 3;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PLEN_W     = 8,
  parameter int unsigned ADDR_W     = 5,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [31:0] KEY        = 32'h0000_5AB9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_i,
  output logic [31:0]       rdata_o,
  output logic [CNT_W-1:0]  reload_o,
  output wd_ctrl_t          ctrl_o,
  output logic [PLEN_W-1:0] plen_o,
  output logic              sts_o,
  output logic              load_o
);
  localparam int unsigned CTRL_W = $bits(wd_ctrl_t);

  wd_reg_e           idx;
  logic              wr_reload, wr_restart, wr_ctrl, wr_clear, wr_plen;
  logic [CNT_W-1:0]  reload_q;
  wd_ctrl_t          ctrl_q;
  logic [PLEN_W-1:0] plen_q;
  logic              sts_q;

  assign idx        = wd_reg_e'(addr_i[IDX_LSB +: IDX_W]);
  assign wr_reload  = wr_en_i && (idx == REG_RELOAD);
  assign wr_restart = wr_en_i && (idx == REG_RESTART);
  assign wr_ctrl    = wr_en_i && (idx == REG_CTRL);
  assign wr_clear   = wr_en_i && (idx == REG_CLEAR);
  assign wr_plen    = wr_en_i && (idx == REG_PLEN);

  // reload on a keyed restart or on a 0->1 edge of the count enable
  assign load_o = (wr_restart && (wdata_i == KEY)) ||
                  (wr_ctrl && wdata_i[0] && !ctrl_q.cnt_en);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= RELOAD_RST;
      ctrl_q   <= '0;
      plen_q   <= '1;
    end else begin
      if (wr_reload) reload_q <= wdata_i[CNT_W-1:0];
      if (wr_ctrl)   ctrl_q   <= wd_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_plen)   plen_q   <= wdata_i[PLEN_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     sts_q <= 1'b0;
    else if (expire_i)               sts_q <= 1'b1;
    else if (wr_clear && wdata_i[0]) sts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      REG_COUNT:  rdata_o[CNT_W-1:0]  = cnt_i;
      REG_RELOAD: rdata_o[CNT_W-1:0]  = reload_q;
      REG_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
      REG_STATUS: rdata_o[0]          = sts_q;
      REG_PLEN:   rdata_o[PLEN_W-1:0] = plen_q;
      default:    rdata_o = '0;
    endcase
  end

  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign plen_o   = plen_q;
  assign sts_o    = sts_q;
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic sel_ext_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick_o = sel_ext_i ? (sync_q[SYNC_STAGES-1] && !prev_q) : 1'b1;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = run_i && tick_i && (cnt_q != '0);
  assign expire_o = step && !load_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (load_i) cnt_q <= reload_i;
    else if (step)   cnt_q <= cnt_q - ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PLEN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [PLEN_W-1:0] len_i,
  output logic              pulse_o
);
  logic [PLEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rem_q <= '0;
    else if (trig_i)        rem_q <= len_i;
    else if (rem_q != '0)   rem_q <= rem_q - PLEN_W'(1);
  end

  assign pulse_o = (rem_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned PLEN_W      = 8,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RELOAD_RST = 32'h03EF1480,
  parameter logic [31:0] KEY         = 32'h0000_5AB9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ext_clk_i,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              ext_sig_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   reload_q;
  logic [PLEN_W-1:0]  plen_q;
  wd_ctrl_t           ctrl_q;
  logic               sts_q;
  logic               load;
  logic               tick;
  logic               expire;
  logic [NUM_OUT-1:0] out_en;
  logic [NUM_OUT-1:0] pulses;

  wdog_regs #(
    .CNT_W(CNT_W), .PLEN_W(PLEN_W), .ADDR_W(ADDR_W),
    .RELOAD_RST(RELOAD_RST), .KEY(KEY)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .expire_i(expire), .rdata_o,
    .reload_o(reload_q), .ctrl_o(ctrl_q), .plen_o(plen_q),
    .sts_o(sts_q), .load_o(load)
  );

  wdog_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i, .rst_ni, .ext_clk_i, .sel_ext_i(ctrl_q.clk_ext), .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .RST_VAL(RELOAD_RST)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .reload_i(reload_q),
    .run_i(ctrl_q.cnt_en), .tick_i(tick), .cnt_o(cnt_q), .expire_o(expire)
  );

  assign out_en = {ctrl_q.ext_en, ctrl_q.irq_en, ctrl_q.rst_en};

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pulse
    wdog_pulse #(.PLEN_W(PLEN_W)) u_pulse (
      .clk_i, .rst_ni, .trig_i(expire && out_en[g]), .len_i(plen_q),
      .pulse_o(pulses[g])
    );
  end

  assign rst_req_o = pulses[0];
  assign irq_o     = pulses[1];
  assign ext_sig_o = pulses[2];
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5,
  parameter logic [31:0] KEY    = 32'h0000_5AB9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rst_req_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              sts,
  input logic              run
);
  logic wr_restart, wr_clear;
  assign wr_restart = wr_en_i && (addr_i[4:2] == 3'd2);
  assign wr_clear   = wr_en_i && (addr_i[4:2] == 3'd5) && wdata_i[0];

  assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_en_i) |=> $stable(cnt));

  assert_key_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_restart && wdata_i == KEY) |=> (cnt == $past(reload)));

  assert_zero_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !wr_en_i) |=> (cnt == '0));

  assert_sticky_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts && !wr_clear) |=> sts);

  assert_pulse_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> (cnt == '0));
endmodule

bind wdog_timer wdog_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rst_req_o,
  .cnt(cnt_q), .reload(reload_q), .sts(sts_q), .run(ctrl_q.cnt_en)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_clk = 1'b0;
  logic        rst_req, irq, ext_sig;

  int total = 0;
  int bad = 0;
  int n_rst = 0, n_irq = 0, n_ext = 0;
  int cycles = 0;
  bit done = 1'b0;

  localparam logic [4:0] A_CNT = 5'h00, A_RLD = 5'h04, A_RST = 5'h08,
                         A_CTL = 5'h0C, A_STS = 5'h10, A_CLR = 5'h14,
                         A_LEN = 5'h18;

  always #2 clk = ~clk;

  wdog_timer u_wdog_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_clk_i(ext_clk),
    .rst_req_o(rst_req), .irq_o(irq), .ext_sig_o(ext_sig)
  );

  always @(negedge clk) begin
    if (rst_req) n_rst++;
    if (irq)     n_irq++;
    if (ext_sig) n_ext++;
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    rd(A_RLD, v); check("R1 reload", v, 32'h03EF1480);
    rd(A_CNT, v); check("R1 counter", v, 32'h03EF1480);
    rd(A_CTL, v); check("R1 ctrl", v, 0);
    rd(A_STS, v); check("R1 status", v, 0);
    rd(A_LEN, v); check("R1 plen", v, 32'hFF);
    check("R1 outputs", {29'd0, rst_req, irq, ext_sig}, 0);
  endtask

  task automatic test_expire();
    logic [31:0] v;
    int r0, i0, e0;
    wr(A_RLD, 10);
    wr(A_LEN, 3);
    wr(A_CTL, 32'h07);
    rd(A_CNT, v); check("R2 enable loads", v, 10);
    step(4);
    rd(A_CNT, v); check("R3 decrement", v, 6);
    r0 = n_rst; i0 = n_irq; e0 = n_ext;
    step(5);
    rd(A_CNT, v); check("R3 one left", v, 1);
    check("R7 no early pulse", {30'd0, rst_req, irq}, 0);
    step(1);
    rd(A_CNT, v); check("R5 counter zero", v, 0);
    rd(A_STS, v); check("R5 status set", v, 1);
    check("R7 pulse start", {29'd0, rst_req, irq, ext_sig}, 3'b110);
    step(2);
    check("R7 pulse last cycle", {31'd0, rst_req}, 1);
    step(1);
    check("R7 pulse end", {30'd0, rst_req, irq}, 0);
    step(10);
    rd(A_CNT, v); check("R5 holds zero", v, 0);
    check("R9 rst once", n_rst - r0, 3);
    check("R9 irq once", n_irq - i0, 3);
    check("R7 ext disabled", n_ext - e0, 0);
  endtask

  task automatic test_clear();
    logic [31:0] v;
    wr(A_CLR, 0);
    rd(A_STS, v); check("R6 zero write no clear", v, 1);
    wr(A_CLR, 1);
    rd(A_STS, v); check("R6 clear", v, 0);
  endtask

  task automatic test_restart();
    logic [31:0] v;
    wr(A_RST, 32'h5AB9);
    rd(A_CNT, v); check("R4 key reload", v, 10);
    step(3);
    wr(A_RST, 32'h1234);
    rd(A_CNT, v); check("R4 bad key ignored", v, 6);
    wr(A_RST, 32'h0001_5AB9);
    rd(A_CNT, v); check("R4 upper bits matter", v, 5);
    wr(A_RST, 32'h5AB9);
    rd(A_CNT, v); check("R4 key again", v, 10);
  endtask

  task automatic test_disable();
    logic [31:0] v;
    wr(A_CTL, 32'h06);
    rd(A_CNT, v); check("R2 last step", v, 9);
    step(5);
    rd(A_CNT, v); check("R2 hold disabled", v, 9);
  endtask

  task automatic test_zero_len();
    logic [31:0] v;
    int r0;
    wr(A_LEN, 0);
    r0 = n_rst;
    wr(A_CTL, 32'h07);
    rd(A_CNT, v); check("R2 re-enable loads", v, 10);
    step(12);
    rd(A_STS, v); check("R5 status zero len", v, 1);
    check("R7 zero length no pulse", n_rst - r0, 0);
    wr(A_CTL, 0);
    wr(A_CLR, 1);
  endtask

  task automatic ext_edge();
    ext_clk = 1'b1; step(4);
    ext_clk = 1'b0; step(4);
  endtask

  task automatic test_ext();
    logic [31:0] v;
    int r0, i0, e0;
    wr(A_RLD, 3);
    wr(A_LEN, 2);
    wr(A_CTL, 32'h1D);
    step(20);
    rd(A_CNT, v); check("R8 no edges no count", v, 3);
    r0 = n_rst; i0 = n_irq; e0 = n_ext;
    ext_edge();
    rd(A_CNT, v); check("R8 one edge", v, 2);
    ext_edge();
    ext_edge();
    step(4);
    rd(A_CNT, v); check("R8 three edges", v, 0);
    rd(A_STS, v); check("R8 status", v, 1);
    check("R7 irq len", n_irq - i0, 2);
    check("R7 ext len", n_ext - e0, 2);
    check("R7 rst disabled", n_rst - r0, 0);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    test_reset();
    test_expire();
    test_clear();
    test_restart();
    test_disable();
    test_zero_len();
    test_ext();
    done = 1'b1;
    finish_run();
  end
endmodule